// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges five reset requests into a single core reset for a small processor subsystem: a synchronized external reset pin, a watchdog pulse, a power-on indication, a brown-out request and a one-cycle software request. Whenever any request is active, the core reset is driven high at once. Release waits for a staged start-up sequence of three phases. The first phase waits for the internal oscillator to settle. The second waits for the flash supply to come up. The third counts the flash initialization cycles. The core reset falls only when the last phase completes and no request remains active.

Every phase length is a parameter. The two analog waits are given in nanoseconds and turned into clock cycles from the clock frequency, so a bench can shorten them. A request that arrives while the sequence is running sends it back to the start of the oscillator phase.

A sticky cause register keeps one bit per source. Power-on wipes every other bit. Software clears bits by writing ones to them. A fetch-address output stays at zero through reset, so the first fetch after release comes from the reset vector.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `core_rst_o` is high in the same cycle that any of `por_i`, `ext_rst_i`, `wdt_rst_i`, `bod_rst_i` or `sw_rst_i` is high, with no clock edge in between.
- R2: The three phases run in a fixed order: oscillator, then flash power, then flash init. `core_rst_o` falls exactly OSC+FPWR+INIT clock edges after the last edge at which any request was sampled high.
- R3: A request sampled during any phase restarts the sequence at the oscillator phase with a zero count, so the full duration is counted again from that edge.
- R4: While `ext_rst_i` is held high, the core stays in reset however long it is held, and counting starts only after it is released.
- R5: A single-cycle `wdt_rst_i` pulse or `sw_rst_i` pulse each starts the full sequence.
- R6: `cause_o` bit 0 records the external pin, bit 1 the watchdog, bit 2 power-on, bit 3 brown-out and bit 4 software. A bit is set in any cycle its request is high and stays set until it is cleared.
- R7: Power-on leaves `cause_o` equal to 5'b00100, clearing every other bit.
- R8: When `clr_we_i` is high, each `cause_o` bit whose `clr_mask_i` bit is 1 is cleared at the next edge. Bits whose mask bit is 0 keep their value. A request in the same cycle sets its bit, and the set wins over the clear.
- R9: `fetch_addr_o` is 0 during reset and in the first cycle after release. After that it advances by ADDR_STEP each cycle.
- R10: Each phase length in cycles is ceil(CLK_MHZ × wait_ns / 1000) for the two waits, and INIT_CYC for the flash init phase. Every phase is at least one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high; also the block's synchronous reset |
| ext_rst_i | input | 1 | External reset pin, already synchronized, active high |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| bod_rst_i | input | 1 | Brown-out reset request |
| sw_rst_i | input | 1 | Software reset write pulse |
| clr_we_i | input | 1 | Write strobe for clearing cause bits |
| clr_mask_i | input | 5 | Cause bits to clear (1 = clear) |
| core_rst_o | output | 1 | Core reset, active high |
| cause_o | output | 5 | Sticky reset-cause bits |
| fetch_addr_o | output | ADDR_W | Processor fetch address |

## Verification
The checks assume that the design starts with `por_i` held high for at least two edges, so every stored value is defined before any past value is compared. They also assume that `por_i` acts as the block's reset, and they are disabled while it is high. The bench asserts power-on first, for several cycles. It then changes every input a short delay after a rising edge, so each request is either sampled at an edge or missed as a whole, and is never half-seen. The sticky and phase-order checks also assume that the clear strobe and the requests are clean single-cycle or level inputs, which the bench's driver tasks guarantee.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_OSC  = 2'd0,
    PH_FPWR = 2'd1,
    PH_INIT = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;

  localparam int NSRC    = 5;
  localparam int SRC_EXT = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_POR = 2;
  localparam int SRC_BOD = 3;
  localparam int SRC_SW  = 4;

  // ceil(mhz * ns / 1000), never below one cycle
  function automatic int ns_to_cyc(input int mhz, input int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/rst_src_merge.sv
module rst_src_merge
  import rst_seq_pkg::*;
(
  input  logic            por_i,
  input  logic            ext_rst_i,
  input  logic            wdt_rst_i,
  input  logic            bod_rst_i,
  input  logic            sw_rst_i,
  output logic [NSRC-1:0] src_vec_o,
  output logic            src_any_o
);

  always_comb begin
    src_vec_o          = '0;
    src_vec_o[SRC_EXT] = ext_rst_i;
    src_vec_o[SRC_WDT] = wdt_rst_i;
    src_vec_o[SRC_POR] = por_i;
    src_vec_o[SRC_BOD] = bod_rst_i;
    src_vec_o[SRC_SW]  = sw_rst_i;
  end

  assign src_any_o = |src_vec_o;

endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rst_seq_pkg::*;
#(
  parameter int OSC_CYC  = 72,
  parameter int FPWR_CYC = 1200,
  parameter int INIT_CYC = 250
) (
  input  logic   clk,
  input  logic   por_i,
  input  logic   src_any_i,
  output phase_t phase_o,
  output logic   hold_o
);

  localparam int MAX_A  = (OSC_CYC > FPWR_CYC) ? OSC_CYC : FPWR_CYC;
  localparam int MAX_C  = (MAX_A > INIT_CYC) ? MAX_A : INIT_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_last;
  phase_t        next_phase;

  always_comb begin
    cur_last   = '0;
    next_phase = PH_RUN;
    case (phase_q)
      PH_OSC:  begin cur_last = CW'(OSC_CYC - 1);  next_phase = PH_FPWR; end
      PH_FPWR: begin cur_last = CW'(FPWR_CYC - 1); next_phase = PH_INIT; end
      PH_INIT: begin cur_last = CW'(INIT_CYC - 1); next_phase = PH_RUN;  end
      default: begin cur_last = '0;                next_phase = PH_RUN;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_i || src_any_i) begin
      phase_q <= PH_OSC;
      cnt_q   <= '0;
    end else if (phase_q != PH_RUN) begin
      if (cnt_q == cur_last) begin
        phase_q <= next_phase;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign hold_o  = (phase_q != PH_RUN);

  // R3: a sampled request always lands at the start of the oscillator phase
  assert_restart_R3: assert property (@(posedge clk) disable iff (por_i)
    src_any_i |=> (phase_q == PH_OSC && cnt_q == '0));

  // R2: phases only step forward by one, or fall back to the oscillator phase
  assert_phase_order_R2: assert property (@(posedge clk) disable iff (por_i)
    (phase_q != $past(phase_q) && phase_q != PH_OSC)
      |-> (2'(phase_q) == 2'($past(phase_q)) + 2'd1));

  // R2: leaving a phase needs a quiet cycle before it
  assert_advance_quiet_R2: assert property (@(posedge clk) disable iff (por_i)
    (phase_q != $past(phase_q) && phase_q != PH_OSC) |-> !$past(src_any_i));

  // R10: the count never passes its phase length
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (por_i)
    cnt_q <= cur_last);

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic            clk,
  input  logic            por_i,
  input  logic [NSRC-1:0] src_vec_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] cause_o
);

  localparam logic [NSRC-1:0] POR_ONLY = NSRC'(1) << SRC_POR;

  logic [NSRC-1:0] cause_q;
  logic [NSRC-1:0] clr_bits;

  assign clr_bits = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (por_i) begin
      cause_q <= POR_ONLY;
    end else begin
      cause_q <= (cause_q & ~clr_bits) | src_vec_i;
    end
  end

  assign cause_o = cause_q;

  // R7: the first cycle after power-on shows only the power-on bit
  assert_por_only_R7: assert property (@(posedge clk) disable iff (por_i)
    $past(por_i) |-> (cause_q == POR_ONLY));

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      // R6: a set bit stays set unless cleared or wiped by power-on
      assert_sticky_R6: assert property (@(posedge clk) disable iff (por_i)
        ($past(cause_q[i]) && !$past(por_i) && !($past(clr_we_i) && $past(clr_mask_i[i])))
          |-> cause_q[i]);
      // R8: a request seen in a cycle is recorded whatever the clear strobe says
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (por_i)
        src_vec_i[i] |=> cause_q[i]);
    end
  endgenerate

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int CLK_MHZ      = 12,
  parameter int OSC_WAIT_NS  = 6000,
  parameter int FPWR_WAIT_NS = 100000,
  parameter int INIT_CYC     = 250,
  parameter int ADDR_W       = 32,
  parameter int ADDR_STEP    = 4
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              wdt_rst_i,
  input  logic              bod_rst_i,
  input  logic              sw_rst_i,
  input  logic              clr_we_i,
  input  logic [4:0]        clr_mask_i,
  output logic              core_rst_o,
  output logic [4:0]        cause_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);

  localparam int OSC_CYC  = ns_to_cyc(CLK_MHZ, OSC_WAIT_NS);
  localparam int FPWR_CYC = ns_to_cyc(CLK_MHZ, FPWR_WAIT_NS);
  localparam int INIT_N   = (INIT_CYC < 1) ? 1 : INIT_CYC;

  logic [NSRC-1:0]   src_vec;
  logic              src_any;
  logic              hold;
  phase_t            phase;
  logic [ADDR_W-1:0] fetch_q;

  rst_src_merge u_merge (
    .por_i     (por_i),
    .ext_rst_i (ext_rst_i),
    .wdt_rst_i (wdt_rst_i),
    .bod_rst_i (bod_rst_i),
    .sw_rst_i  (sw_rst_i),
    .src_vec_o (src_vec),
    .src_any_o (src_any)
  );

  rst_phase_seq #(
    .OSC_CYC  (OSC_CYC),
    .FPWR_CYC (FPWR_CYC),
    .INIT_CYC (INIT_N)
  ) u_seq (
    .clk       (clk),
    .por_i     (por_i),
    .src_any_i (src_any),
    .phase_o   (phase),
    .hold_o    (hold)
  );

  rst_cause_reg u_cause (
    .clk        (clk),
    .por_i      (por_i),
    .src_vec_i  (src_vec),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .cause_o    (cause_o)
  );

  // requests raise reset without waiting for a clock edge; release is registered
  assign core_rst_o = src_any | hold;

  always_ff @(posedge clk) begin
    if (por_i || core_rst_o) begin
      fetch_q <= '0;
    end else begin
      fetch_q <= fetch_q + ADDR_W'(ADDR_STEP);
    end
  end

  assign fetch_addr_o = fetch_q;

  // R9: the first fetch after release comes from address zero
  assert_vector_zero_R9: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> (fetch_addr_o == '0));

  // R2: release only follows the flash init phase
  assert_release_after_init_R2: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> ($past(phase) == PH_INIT));

  // R4: a held external pin keeps the sequence at the oscillator phase
  assert_ext_hold_R4: assert property (@(posedge clk) disable iff (por_i)
    (ext_rst_i && $past(ext_rst_i)) |-> (phase == PH_OSC));

endmodule

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;

  localparam int CLK_MHZ = 10;
  localparam int OSC_NS  = 1050;
  localparam int FPWR_NS = 2000;
  localparam int INIT_N  = 15;
  // R10: ceil(10*1050/1000)=11, ceil(10*2000/1000)=20
  localparam int T_OSC   = (CLK_MHZ * OSC_NS + 999) / 1000;
  localparam int T_FPWR  = (CLK_MHZ * FPWR_NS + 999) / 1000;
  localparam int T_TOT   = T_OSC + T_FPWR + INIT_N;
  // monitor counts from the negedge before the last sampling edge: one extra
  localparam int LAT     = T_TOT + 1;

  logic        clk = 1'b0;
  logic        por = 1'b1, ext = 1'b0, wdt = 1'b0, bod = 1'b0, sw = 1'b0;
  logic        clr_we = 1'b0;
  logic [4:0]  clr_mask = '0;
  logic        core_rst;
  logic [4:0]  cause;
  logic [31:0] fetch;

  always #2 clk = ~clk;

  rst_seq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .OSC_WAIT_NS(OSC_NS), .FPWR_WAIT_NS(FPWR_NS),
    .INIT_CYC(INIT_N), .ADDR_W(32), .ADDR_STEP(4)
  ) u_rst_seq_ctrl (
    .clk(clk), .por_i(por), .ext_rst_i(ext), .wdt_rst_i(wdt),
    .bod_rst_i(bod), .sw_rst_i(sw), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .core_rst_o(core_rst), .cause_o(cause), .fetch_addr_o(fetch)
  );

  typedef struct {
    int         lat;
    logic [4:0] cause;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0, n_bad = 0;
  int   cyc = 0, last_src = 0;
  logic prev_rst = 1'bx;

  function automatic void chk(input string req, input string what,
                              input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: on every release, pop the expected item and compare
  always @(negedge clk) begin : monitor
    exp_t e;
    if (por | ext | wdt | bod | sw) last_src = cyc;
    if (prev_rst === 1'b1 && core_rst === 1'b0) begin
      if (sb_q.size() == 0) begin
        chk("R2", "unexpected release", 1, 0);
      end else begin
        e = sb_q.pop_front();
        chk({e.req, " R2 R10"}, "release latency", cyc - last_src, e.lat);
        chk({e.req, " R6"}, "cause", cause, e.cause);
        chk("R9", "first fetch address", fetch, 0);
      end
    end
    prev_rst = core_rst;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rel(input logic [4:0] c, input string req);
    exp_t e;
    e.lat = LAT; e.cause = c; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic wait_drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    longint f0;
    // reset state under power-on (R1, R9)
    repeat (5) step();
    @(negedge clk);
    chk("R1", "core reset during power-on", core_rst, 1);
    chk("R9", "fetch during reset", fetch, 0);
    expect_rel(5'b00100, "R7");
    step(); por = 1'b0;
    wait_drain();
    chk("R7", "cause after power-on", cause, 5'b00100);
    f0 = fetch;
    @(negedge clk);
    chk("R9", "fetch step", fetch, f0 + 4);

    // R4: long external hold
    step(); ext = 1'b1;
    expect_rel(5'b00101, "R4");
    repeat (100) step();
    @(negedge clk);
    chk("R4", "reset held by pin", core_rst, 1);
    step(); ext = 1'b0;
    wait_drain();

    // R8: clear only the external bit
    step(); clr_we = 1'b1; clr_mask = 5'b00001;
    step(); clr_we = 1'b0; clr_mask = '0;
    @(negedge clk);
    chk("R8", "partial clear", cause, 5'b00100);

    // R5: watchdog pulse
    step(); wdt = 1'b1;
    expect_rel(5'b00110, "R5");
    step(); wdt = 1'b0;
    wait_drain();

    // R8: clear everything
    step(); clr_we = 1'b1; clr_mask = 5'b11111;
    step(); clr_we = 1'b0; clr_mask = '0;
    @(negedge clk);
    chk("R8", "full clear", cause, 5'b00000);

    // R3: brown-out, then software request mid-sequence restarts counting
    step(); bod = 1'b1;
    step(); bod = 1'b0;
    repeat (25) step();
    @(negedge clk);
    chk("R3", "still in reset mid-sequence", core_rst, 1);
    step(); sw = 1'b1;
    expect_rel(5'b11000, "R3 R5");
    step(); sw = 1'b0;
    wait_drain();

    // R8: set beats clear in the same cycle
    step(); sw = 1'b1; clr_we = 1'b1; clr_mask = 5'b10000;
    expect_rel(5'b11000, "R8");
    step(); sw = 1'b0; clr_we = 1'b0; clr_mask = '0;
    wait_drain();

    // R1: reset rises in the same cycle as the request
    step();
    chk("R1", "running before request", core_rst, 0);
    bod = 1'b1;
    #1;
    chk("R1", "immediate reset", core_rst, 1);
    expect_rel(5'b11000, "R1");
    step(); bod = 1'b0;
    wait_drain();

    // R7: power-on wipes the other causes
    step(); por = 1'b1;
    expect_rel(5'b00100, "R7");
    repeat (3) step();
    por = 1'b0;
    wait_drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule